// File: doc/BRIEF.md
# Statistics Settings Commit and Freeze Controller

This block sits between a software register port and a video statistics engine. Software writes the colour filter arrangement, the region bounds, the zone dimensions and the four ratio limits into a shadow set of registers. None of these writes reaches the engine directly. A write to the commit word marks the shadow set as pending. The next frame start then copies the whole set into the active outputs at once, so a frame is never processed with half old and half new settings.

A second mechanism gives software a coherent snapshot. Software raises a freeze request bit. The block waits for the next frame start and lets the engine gather that one complete frame. At that frame's end it reports frozen and drives a hold output that stops all further updates. The hold lasts until software lowers the request. A pending commit never delays this sequence.

The block also keeps an 8-bit checksum of each frame. The checksum is frozen together with the other statistics.

Top module: `stats_cfg_freeze_ctrl`

## Requirements
- R1: A write to CONTROL (word 3), to a position word (words 4..9, in the order h-start, v-start, h-end, v-end, zone width, zone height) or to a limit word (words 10..13) updates only the shadow copy. A read of that word returns the shadow value one cycle after the read strobe. CONTROL reads back its bit 31, its bits 4:1 and zeros elsewhere. The outputs cfg_cfa, cfg_pos and cfg_range keep their values.
- R2: A write of any data to the commit word (word 2) sets the pending flag. STATUS (word 0) bit 1 reads 1 while the flag is set.
- R3: When a frame start arrives while the pending flag is set, the shadow set is copied to the active outputs in that cycle and the flag clears. The active outputs change at no other time. cfg_cfa is {CONTROL bits 4:3, CONTROL bits 2:1}. cfg_pos and cfg_range pack their words with the lowest word index in the least significant slice.
- R4: STATUS bit 0 reads 1 from the cycle after a frame start until the cycle after the frame end, and 0 outside that span.
- R5: The freeze request is CONTROL bit 31. When the request is 1 at a frame start, that frame is captured. At its frame end, STATUS bit 2 and stats_hold become 1.
- R6: While the request stays 1 after frozen is reported, STATUS bit 2, stats_hold and the checksum stay unchanged through later frames. One cycle after the request reads 0, frozen and stats_hold clear and checksum updates resume.
- R7: A request raised in the middle of a frame does not capture that frame. That frame's end leaves frozen at 0 and still updates the checksum. The following frame is the one captured.
- R8: A pending commit does not delay or block a freeze. A commit written during a capture frame stays pending while frozen is reported (STATUS = 6), and it applies at the next frame start.
- R9: The checksum word (word 1) returns, in bits 7:0, the modulo-256 sum of the samples with pix_valid high between frame start and frame end. It is latched at frame end. Samples with pix_valid low are ignored, and bits 31:8 read 0.
- R10: After reset, STATUS, the checksum, all shadow and active settings, and stats_hold are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register word index |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe; reg_rdata is updated on the next edge |
| reg_rdata | output | 32 | Registered read data |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| frame_end | input | 1 | One-cycle pulse at the end of a frame |
| pix_valid | input | 1 | Sample on pix_data is valid |
| pix_data | input | PIX_W | Pixel sample |
| cfg_cfa | output | 4 | Active filter phase (bits 1:0) and phase invert (bits 3:2) |
| cfg_pos | output | 6*POS_W | Active region bounds and zone size |
| cfg_range | output | 4*RANGE_W | Active ratio limits |
| stats_hold | output | 1 | Engine must not update its statistics |

## Verification
Checksums are tried with four patterns: a short stride ramp, a 300-sample ramp that wraps the modulo sum several times, a constant-zero frame, and a gapped frame in which invalid cycles carry a non-zero value. The gapped frame is the pattern that shows invalid samples are ignored. A commit written in the middle of a frame is observed on the active outputs at that frame's end and again after the next frame start, which tells a boundary-gated copy from an immediate one. Freeze requests are raised both between frames and in the middle of a frame, so the bench can tell the difference between capturing the current frame and capturing the next one. A further frame is run while frozen with different data. This shows the hold is real, and a commit raised during capture shows the two mechanisms do not block each other.

// File: rtl/scfc_pkg.sv
package scfc_pkg;
  localparam int A_STATUS = 0;
  localparam int A_CSUM   = 1;
  localparam int A_COMMIT = 2;
  localparam int A_CTRL   = 3;
  localparam int A_POS0   = 4;
  localparam int N_POS    = 6;
  localparam int A_RNG0   = A_POS0 + N_POS;
  localparam int N_RNG    = 4;
  localparam int CSUM_W   = 8;

  typedef enum logic [1:0] {
    FZ_FREE,
    FZ_WAIT,
    FZ_CAP,
    FZ_HOLD
  } fz_state_t;
endpackage

// File: rtl/scfc_cfg_shadow.sv
module scfc_cfg_shadow
  import scfc_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int POS_W   = 16,
  parameter int RANGE_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [31:0]              wdata,
  input  logic                     frame_start,
  output logic                     freeze_req,
  output logic                     pending,
  output logic [3:0]               ctrl_sh,
  output logic [N_POS*POS_W-1:0]   pos_sh,
  output logic [N_RNG*RANGE_W-1:0] rng_sh,
  output logic [3:0]               ctrl_act,
  output logic [N_POS*POS_W-1:0]   pos_act,
  output logic [N_RNG*RANGE_W-1:0] rng_act
);
  logic commit_wr;
  logic apply;

  assign commit_wr = wr && (addr == ADDR_W'(A_COMMIT));
  assign apply     = frame_start && pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      freeze_req <= 1'b0;
      ctrl_sh    <= '0;
      pos_sh     <= '0;
      rng_sh     <= '0;
    end else if (wr) begin
      if (addr == ADDR_W'(A_CTRL)) begin
        freeze_req <= wdata[31];
        ctrl_sh    <= wdata[4:1];
      end
      for (int i = 0; i < N_POS; i++) begin
        if (addr == ADDR_W'(A_POS0 + i))
          pos_sh[i*POS_W +: POS_W] <= wdata[POS_W-1:0];
      end
      for (int j = 0; j < N_RNG; j++) begin
        if (addr == ADDR_W'(A_RNG0 + j))
          rng_sh[j*RANGE_W +: RANGE_W] <= wdata[RANGE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      ctrl_act <= '0;
      pos_act  <= '0;
      rng_act  <= '0;
    end else begin
      if (apply) begin
        ctrl_act <= ctrl_sh;
        pos_act  <= pos_sh;
        rng_act  <= rng_sh;
      end
      if (commit_wr)
        pending <= 1'b1;
      else if (apply)
        pending <= 1'b0;
    end
  end
endmodule

// File: rtl/scfc_freeze_fsm.sv
module scfc_freeze_fsm
  import scfc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic frame_start,
  input  logic frame_end,
  output logic frozen
);
  fz_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      FZ_FREE: if (req) state_nx = FZ_WAIT;
      FZ_WAIT: if (!req) state_nx = FZ_FREE;
               else if (frame_start) state_nx = FZ_CAP;
      FZ_CAP:  if (!req) state_nx = FZ_FREE;
               else if (frame_end) state_nx = FZ_HOLD;
      FZ_HOLD: if (!req) state_nx = FZ_FREE;
      default: state_nx = FZ_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= FZ_FREE;
    else     state <= state_nx;
  end

  assign frozen = (state == FZ_HOLD);
endmodule

// File: rtl/scfc_frame_csum.sv
module scfc_frame_csum
  import scfc_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              hold,
  output logic [CSUM_W-1:0] csum
);
  logic [CSUM_W-1:0] acc, acc_nx, base, add;

  assign base   = frame_start ? '0 : acc;
  assign add    = pix_valid ? pix_data[CSUM_W-1:0] : '0;
  assign acc_nx = base + add;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      csum <= '0;
    end else begin
      acc <= acc_nx;
      if (frame_end && !hold) csum <= acc_nx;
    end
  end
endmodule

// File: rtl/stats_cfg_freeze_ctrl.sv
module stats_cfg_freeze_ctrl
  import scfc_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int PIX_W   = 8,
  parameter int POS_W   = 16,
  parameter int RANGE_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic                     reg_wr,
  input  logic [31:0]              reg_wdata,
  input  logic                     reg_rd,
  output logic [31:0]              reg_rdata,
  input  logic                     frame_start,
  input  logic                     frame_end,
  input  logic                     pix_valid,
  input  logic [PIX_W-1:0]         pix_data,
  output logic [3:0]               cfg_cfa,
  output logic [N_POS*POS_W-1:0]   cfg_pos,
  output logic [N_RNG*RANGE_W-1:0] cfg_range,
  output logic                     stats_hold
);
  logic                     freeze_req, cfg_pending, frz_frozen, running_q;
  logic [3:0]               ctrl_sh;
  logic [N_POS*POS_W-1:0]   pos_sh;
  logic [N_RNG*RANGE_W-1:0] rng_sh;
  logic [CSUM_W-1:0]        csum_q;
  logic [31:0]              rd_nx;

  scfc_cfg_shadow #(.ADDR_W(ADDR_W), .POS_W(POS_W), .RANGE_W(RANGE_W)) u_cfg (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .frame_start(frame_start), .freeze_req(freeze_req), .pending(cfg_pending),
    .ctrl_sh(ctrl_sh), .pos_sh(pos_sh), .rng_sh(rng_sh),
    .ctrl_act(cfg_cfa), .pos_act(cfg_pos), .rng_act(cfg_range)
  );

  scfc_freeze_fsm u_fsm (
    .clk(clk), .rst(rst), .req(freeze_req), .frame_start(frame_start),
    .frame_end(frame_end), .frozen(frz_frozen)
  );

  scfc_frame_csum #(.PIX_W(PIX_W)) u_csum (
    .clk(clk), .rst(rst), .frame_start(frame_start), .frame_end(frame_end),
    .pix_valid(pix_valid), .pix_data(pix_data), .hold(frz_frozen), .csum(csum_q)
  );

  assign stats_hold = frz_frozen;

  always_ff @(posedge clk) begin
    if (rst)              running_q <= 1'b0;
    else if (frame_start) running_q <= 1'b1;
    else if (frame_end)   running_q <= 1'b0;
  end

  always_comb begin
    rd_nx = '0;
    if (reg_addr == ADDR_W'(A_STATUS))
      rd_nx = {29'd0, frz_frozen, cfg_pending, running_q};
    if (reg_addr == ADDR_W'(A_CSUM))
      rd_nx = {{(32-CSUM_W){1'b0}}, csum_q};
    if (reg_addr == ADDR_W'(A_CTRL))
      rd_nx = {freeze_req, 26'd0, ctrl_sh, 1'b0};
    for (int i = 0; i < N_POS; i++)
      if (reg_addr == ADDR_W'(A_POS0 + i))
        rd_nx = 32'(pos_sh[i*POS_W +: POS_W]);
    for (int j = 0; j < N_RNG; j++)
      if (reg_addr == ADDR_W'(A_RNG0 + j))
        rd_nx = 32'(rng_sh[j*RANGE_W +: RANGE_W]);
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_nx;
  end
endmodule

// File: rtl/stats_cfg_freeze_chk.sv
module stats_cfg_freeze_chk #(
  parameter int POS_W = 96,
  parameter int CS_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_start,
  input logic             frame_end,
  input logic             reg_wr,
  input logic             pending,
  input logic             frozen,
  input logic             req,
  input logic             running,
  input logic [POS_W-1:0] cfg_pos,
  input logic [3:0]       cfg_cfa,
  input logic [CS_W-1:0]  csum
);
  // R3: the active set only moves on a frame start
  a_r3_pos_stable: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(cfg_pos) && $stable(cfg_cfa));

  // R3: a pending flag is consumed by a frame start without a new commit
  a_r3_pending_clears: assert property (@(posedge clk) disable iff (rst)
    pending && frame_start && !reg_wr |=> !pending);

  // R4: running follows the frame pulses
  a_r4_running_set: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> running);

  // R6: frozen persists while the request is held
  a_r6_hold_while_req: assert property (@(posedge clk) disable iff (rst)
    frozen && req |=> frozen);

  // R6: the checksum does not move while frozen
  a_r6_csum_stable: assert property (@(posedge clk) disable iff (rst)
    frozen |=> $stable(csum));

  // R5: frozen only rises at a frame end
  a_r5_rise_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(frozen) |-> $past(frame_end));
endmodule

bind stats_cfg_freeze_ctrl stats_cfg_freeze_chk #(.POS_W(scfc_pkg::N_POS*POS_W), .CS_W(scfc_pkg::CSUM_W)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .frame_end(frame_end),
  .reg_wr(reg_wr), .pending(cfg_pending), .frozen(frz_frozen), .req(freeze_req),
  .running(running_q), .cfg_pos(cfg_pos), .cfg_cfa(cfg_cfa), .csum(csum_q)
);

// File: tb/tb_stats_cfg_freeze_ctrl.sv
module tb_stats_cfg_freeze_ctrl;
  localparam int ADDR_W = 4, PIX_W = 8, POS_W = 16, RANGE_W = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic frame_start = 1'b0, frame_end = 1'b0, pix_valid = 1'b0;
  logic [PIX_W-1:0] pix_data = '0;
  logic [3:0] cfg_cfa;
  logic [6*POS_W-1:0] cfg_pos;
  logic [4*RANGE_W-1:0] cfg_range;
  logic stats_hold;

  stats_cfg_freeze_ctrl #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .POS_W(POS_W), .RANGE_W(RANGE_W)) dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .frame_start(frame_start), .frame_end(frame_end),
    .pix_valid(pix_valid), .pix_data(pix_data), .cfg_cfa(cfg_cfa), .cfg_pos(cfg_pos),
    .cfg_range(cfg_range), .stats_hold(stats_hold)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0, cur_sum = 0, exp_last = 0;
  int exp_q[$];
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(posedge clk); #1 reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] v);
    @(posedge clk); #1 reg_rd = 1'b1; reg_addr = ADDR_W'(a);
    @(posedge clk); #1 reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic chk_reg(input string req, input int a, input logic [31:0] exp);
    logic [31:0] v;
    rd_reg(a, v);
    chk(req, v, exp);
  endtask

  task automatic fstart();
    @(posedge clk); #1 frame_start = 1'b1; cur_sum = 0;
    @(posedge clk); #1 frame_start = 1'b0;
  endtask

  task automatic pixels(input int n, input int base, input int step, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 pix_valid = 1'b1; pix_data = PIX_W'(base + i * step);
      cur_sum += (base + i * step) & 255;
      if (gaps) begin
        @(posedge clk); #1 pix_valid = 1'b0; pix_data = 8'hA5;
      end
    end
    @(posedge clk); #1 pix_valid = 1'b0;
  endtask

  // driver side: the frame end pushes the checksum value software should read
  task automatic fend(input bit latch);
    @(posedge clk); #1 frame_end = 1'b1;
    @(posedge clk); #1 frame_end = 1'b0;
    if (latch) exp_last = cur_sum & 255;
    exp_q.push_back(exp_last);
  endtask

  // monitor side: pop the expected checksum and compare to the register
  task automatic chk_csum(input string req);
    logic [31:0] v;
    int e;
    rd_reg(1, v);
    e = exp_q.pop_front();
    chk(req, v, 32'(e));
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R10 reset state
    chk("R10 cfg_pos", 32'(cfg_pos), 0);
    chk("R10 cfg_cfa", 32'(cfg_cfa), 0);
    chk("R10 hold", 32'(stats_hold), 0);
    chk_reg("R10 status", 0, 0);
    chk_reg("R10 csum", 1, 0);
    chk_reg("R10 ctrl", 3, 0);

    // R1 shadow writes
    wr_reg(3, 32'hFFFF_FF16);
    for (int i = 0; i < 6; i++) wr_reg(4 + i, 32'hABC0_0010 + i);
    for (int j = 0; j < 4; j++) wr_reg(10 + j, 32'h1234_0000 + j);
    chk_reg("R1 ctrl readback", 3, 32'h8000_0016);
    wr_reg(3, 32'h0000_0016);
    chk_reg("R1 pos readback", 5, 32'h0000_0011);
    chk_reg("R1 range readback", 12, 32'h1234_0002);
    chk("R1 cfa unchanged", 32'(cfg_cfa), 0);
    chk("R1 pos unchanged", 32'(cfg_pos[31:0]), 0);
    chk_reg("R2 no commit", 0, 0);
    wr_reg(2, 32'hDEAD_BEEF);
    chk_reg("R2 pending", 0, 2);

    // R3 apply at frame start
    fstart();
    chk("R3 cfa applied", 32'(cfg_cfa), 32'hB);
    chk("R3 hstart", 32'(cfg_pos[15:0]), 32'h10);
    chk("R3 zone_v", 32'(cfg_pos[95:80]), 32'h15);
    chk("R3 range x1hi", cfg_range[127:96], 32'h1234_0003);
    chk_reg("R4 running, R3 pending cleared", 0, 1);

    // mid-frame commit
    pixels(10, 3, 7, 1'b0);
    wr_reg(8, 32'h40);
    wr_reg(2, 0);
    chk("R3 mid-frame zone old", 32'(cfg_pos[79:64]), 32'h14);
    pixels(4, 9, 1, 1'b0);
    fend(1'b1);
    chk_reg("R4 idle, R2 pending", 0, 2);
    chk("R3 still old after end", 32'(cfg_pos[79:64]), 32'h14);
    chk_csum("R9 stride ramp");
    fstart();
    chk("R3 zone new next frame", 32'(cfg_pos[79:64]), 32'h40);
    chk_reg("R3 pending cleared", 0, 1);
    pixels(300, 0, 1, 1'b0);
    fend(1'b1);
    chk_csum("R9 wrapping ramp");
    fstart(); pixels(20, 8'hF0, 3, 1'b1); fend(1'b1);
    chk_csum("R9 gaps ignored");
    fstart(); pixels(5, 0, 0, 1'b0); fend(1'b1);
    chk_csum("R9 zero frame");

    // R5 freeze between frames
    wr_reg(3, 32'h8000_0016);
    chk_reg("R5 not frozen before capture", 0, 0);
    fstart(); pixels(8, 1, 2, 1'b0);
    chk("R5 hold low during capture", 32'(stats_hold), 0);
    fend(1'b1);
    chk_reg("R5 frozen", 0, 4);
    chk("R5 hold", 32'(stats_hold), 1);
    chk_csum("R5 captured csum");
    // R6 stays frozen
    fstart(); pixels(7, 50, 9, 1'b0); fend(1'b0);
    chk_csum("R6 csum held");
    chk_reg("R6 still frozen", 0, 4);
    wr_reg(3, 32'h0000_0016);
    chk_reg("R6 released", 0, 0);
    chk("R6 hold released", 32'(stats_hold), 0);
    fstart(); pixels(6, 77, 5, 1'b0); fend(1'b1);
    chk_csum("R6 updates resume");

    // R7 mid-frame request
    fstart(); pixels(6, 2, 2, 1'b0);
    wr_reg(3, 32'h8000_0016);
    pixels(3, 100, 1, 1'b0);
    fend(1'b1);
    chk_reg("R7 not frozen by current frame", 0, 0);
    chk_csum("R7 csum updated");
    fstart(); pixels(5, 200, 13, 1'b0); fend(1'b1);
    chk_reg("R7 frozen after next", 0, 4);
    chk_csum("R7 captured next frame");
    wr_reg(3, 32'h0000_0016);

    // R8 commit during capture does not block freeze
    wr_reg(3, 32'h8000_0016);
    fstart(); pixels(4, 1, 1, 1'b0);
    wr_reg(9, 32'h22);
    wr_reg(2, 1);
    fend(1'b1);
    chk_reg("R8 frozen with pending", 0, 6);
    chk_csum("R8 captured csum");
    fstart();
    chk("R8 commit applied while frozen", 32'(cfg_pos[95:80]), 32'h22);
    wr_reg(3, 32'h0000_0016);
    fend(1'b0);
    exp_q.delete();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule